// File: doc/BRIEF.md
# Reciprocal Newton-Raphson Refinement Datapath

This block sharpens a coarse reciprocal seed into a reciprocal that is correct to the last bit of a 24-bit fraction. It evaluates R = R0 × (2 − b × R0) in two issues through one shared pipeline. The first issue multiplies the normalized significand b by the seed R0. It rounds the fractional part of the product to 32 bits and bit-inverts it, which gives the correction term minus one. It then keeps only the low 24 bits of that term. The second issue takes that 24-bit word in place of b, sign-extends it back to 32 bits, multiplies it by R0, adds R0 itself and a fixed bias, and rounds to 24 fraction bits.

Each issue takes three register stages, so a full refinement costs six cycles. A new operation of either kind can be accepted on every clock, and the two kinds may be freely interleaved. Sign, exponent and seed generation belong to the surrounding unit.

Operand formats: `in_opnd` carries b as an unsigned 1.23 value in [1,2) with the leading one explicit, or the 24-bit intermediate of a previous product issue. `in_seed` and the final result are unsigned 1.24 values in (0.5,1]. The step code 0 selects the product issue and 1 selects the finish issue.

Top module: `nr_recip_refine`

## Requirements
- R1: For a product issue with operands b and s, P = b·s. Let F = bits 46..15 of (P + 2^14), and let C = the bitwise NOT of F. The result is bits 23..0 of C.
- R2: A product-issue result always has bit 24 of `out_data` equal to 0.
- R3: For a finish issue with intermediate m and seed s, let e be m read as a signed 24-bit number. The result is bits 56..32 of (s·2^32 + s·e + BIAS + 2^31), with BIAS defaulting to 2^24.
- R4: An operation sampled at clock edge n appears on the outputs right after edge n+2.
- R5: `out_valid` copies `in_valid` delayed by three edges, including one result per edge under back-to-back issue.
- R6: While `out_valid` is low, `out_data` keeps its previous value.
- R7: During reset, `out_valid`, `out_step` and `out_data` are all zero.
- R8: Take a seed within 2^-14 relative error of 1/b. A product issue followed by a finish issue with the same seed gives a result within 1 unit of 2^47/b, and inside [2^23, 2^24].
- R9: `out_step` returns the step code of the operation that produced the current result.
- R10: Product and finish issues interleaved on consecutive cycles do not disturb each other.
- R11: The 8 bits that a product issue drops, together with the top kept bit, are all equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_step | input | 1 | 0 = product issue, 1 = finish issue |
| in_opnd | input | 24 | Significand b, or the intermediate word |
| in_seed | input | 25 | Seed reciprocal R0, 1.24 format |
| out_valid | output | 1 | Result present |
| out_step | output | 1 | Step code of the result |
| out_data | output | 25 | Intermediate (bits 23..0) or final reciprocal (1.24) |

## Verification
The range check on finished results and the check on identical dropped bits both assume that each seed is a genuine approximation of 1/b, good to about 14 bits. They also assume that each finish operand is the product-issue output for the same seed. With any other operands, the packed term no longer fits in 24 bits. The stimulus therefore draws b at random in [1,2) and sets the seed to the rounded ideal reciprocal plus a bounded offset of at most 512 units, clamped to (2^23, 2^24]. Finish operands are only ever produced from such pairs, either by the bench's model or by feeding the block's own product results back.

// File: rtl/nr_pkg.sv
package nr_pkg;
    localparam int SIG_W   = 24;                 // significand / intermediate width
    localparam int SEED_W  = SIG_W + 1;          // 1.24 seed and result
    localparam int MID_W   = 32;                 // rounded correction width
    localparam int DROP_W  = MID_W - SIG_W;      // bits removed when packing
    localparam int OPX_W   = MID_W + 1;          // signed multiplier operand X
    localparam int OPY_W   = SEED_W + 1;         // signed multiplier operand Y
    localparam int PROD_W  = OPX_W + OPY_W;      // signed product
    localparam int ACC_W   = PROD_W + 1;         // finish accumulator
    localparam int PFRAC   = 2 * SIG_W - 1;      // fraction bits of b*R0
    localparam int SH1     = PFRAC - MID_W;      // bits rounded away in product issue

    typedef enum logic {
        STEP_PRODUCT = 1'b0,
        STEP_FINISH  = 1'b1
    } nr_step_e;

    typedef struct packed {
        logic              vld;
        nr_step_e          step;
        logic [SEED_W-1:0] seed;
    } nr_tag_t;
endpackage

// File: rtl/nr_operand_stage.sv
module nr_operand_stage
    import nr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  nr_step_e                in_step,
    input  logic [SIG_W-1:0]        in_opnd,
    input  logic [SEED_W-1:0]       in_seed,
    output nr_tag_t                 tag_q,
    output logic signed [OPX_W-1:0] opx_q,
    output logic signed [OPY_W-1:0] opy_q
);
    logic signed [OPX_W-1:0] opx_d;

    // Product issue: b is unsigned. Finish issue: intermediate is sign-extended.
    always_comb begin
        unique case (in_step)
            STEP_PRODUCT: opx_d = {{(OPX_W-SIG_W){1'b0}}, in_opnd};
            STEP_FINISH:  opx_d = {{(OPX_W-SIG_W){in_opnd[SIG_W-1]}}, in_opnd};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            opx_q <= '0;
            opy_q <= '0;
        end else begin
            tag_q.vld <= in_valid;
            if (in_valid) begin
                tag_q.step <= in_step;
                tag_q.seed <= in_seed;
                opx_q      <= opx_d;
                opy_q      <= {1'b0, in_seed};
            end
        end
    end
endmodule

// File: rtl/nr_mul_stage.sv
module nr_mul_stage
    import nr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  nr_tag_t                  tag_d,
    input  logic signed [OPX_W-1:0]  opx,
    input  logic signed [OPY_W-1:0]  opy,
    output nr_tag_t                  tag_q,
    output logic signed [PROD_W-1:0] prod_q
);
    logic signed [PROD_W-1:0] prod_d;

    always_comb prod_d = PROD_W'(opx) * PROD_W'(opy);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            prod_q <= '0;
        end else begin
            tag_q.vld <= tag_d.vld;
            if (tag_d.vld) begin
                tag_q.step <= tag_d.step;
                tag_q.seed <= tag_d.seed;
                prod_q     <= prod_d;
            end
        end
    end
endmodule

// File: rtl/nr_result_stage.sv
module nr_result_stage
    import nr_pkg::*;
#(
    parameter longint unsigned BIAS = 64'd16777216
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  nr_tag_t                  tag_d,
    input  logic signed [PROD_W-1:0] prod,
    output logic                     out_valid,
    output nr_step_e                 out_step,
    output logic [SEED_W-1:0]        out_data,
    output logic [DROP_W:0]          pack_head
);
    localparam logic [PROD_W-1:0] RND1 = PROD_W'(1) << (SH1 - 1);
    localparam logic [ACC_W-1:0]  RND2 = ACC_W'(1) << (MID_W - 1);
    localparam logic [ACC_W-1:0]  BIASV = ACC_W'(BIAS);

    logic [PROD_W-1:0] rnd;
    logic [MID_W-1:0]  frac32;
    logic [MID_W-1:0]  corr;
    logic [ACC_W-1:0]  seed_sh;
    logic [ACC_W-1:0]  prod_x;
    logic [ACC_W-1:0]  acc;
    logic [SEED_W-1:0] data_d;

    // Product issue: round fraction to 32 bits, invert, keep low 24 bits.
    always_comb begin
        rnd       = prod + RND1;
        frac32    = rnd[SH1 +: MID_W];
        corr      = ~frac32;
        pack_head = corr[MID_W-1:SIG_W-1];
    end

    // Finish issue: R0 + R0*e + bias, rounded to 24 fraction bits.
    always_comb begin
        seed_sh = {{(ACC_W-SEED_W-MID_W){1'b0}}, tag_d.seed, {MID_W{1'b0}}};
        prod_x  = {prod[PROD_W-1], prod};
        acc     = seed_sh + prod_x + BIASV + RND2;
    end

    always_comb begin
        unique case (tag_d.step)
            STEP_PRODUCT: data_d = {1'b0, corr[SIG_W-1:0]};
            STEP_FINISH:  data_d = acc[MID_W +: SEED_W];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_step  <= STEP_PRODUCT;
            out_data  <= '0;
        end else begin
            out_valid <= tag_d.vld;
            if (tag_d.vld) begin
                out_step <= tag_d.step;
                out_data <= data_d;
            end
        end
    end
endmodule

// File: rtl/nr_recip_refine.sv
module nr_recip_refine
    import nr_pkg::*;
#(
    parameter longint unsigned BIAS = 64'd16777216
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_step,
    input  logic [23:0]       in_opnd,
    input  logic [24:0]       in_seed,
    output logic              out_valid,
    output logic              out_step,
    output logic [24:0]       out_data
);
    nr_tag_t                  tag_a;
    nr_tag_t                  tag_b;
    logic signed [OPX_W-1:0]  opx;
    logic signed [OPY_W-1:0]  opy;
    logic signed [PROD_W-1:0] prod;
    nr_step_e                 res_step;
    logic [DROP_W:0]          pack_head;
    logic                     pack_en;

    nr_operand_stage u_operand (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_step  (nr_step_e'(in_step)),
        .in_opnd  (in_opnd),
        .in_seed  (in_seed),
        .tag_q    (tag_a),
        .opx_q    (opx),
        .opy_q    (opy)
    );

    nr_mul_stage u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_d  (tag_a),
        .opx    (opx),
        .opy    (opy),
        .tag_q  (tag_b),
        .prod_q (prod)
    );

    nr_result_stage #(.BIAS(BIAS)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .tag_d     (tag_b),
        .prod      (prod),
        .out_valid (out_valid),
        .out_step  (res_step),
        .out_data  (out_data),
        .pack_head (pack_head)
    );

    assign out_step = res_step;
    assign pack_en  = tag_b.vld && (tag_b.step == STEP_PRODUCT);
endmodule

// File: rtl/nr_refine_chk.sv
module nr_refine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic        out_step,
    input logic [24:0] out_data,
    input logic        pack_en,
    input logic [8:0]  pack_head
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cyc <= 2'd0;
        else if (cyc != 3) cyc <= cyc + 2'd1;
    end

    // R5
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !out_valid) |-> $stable(out_data));

    // R2
    packed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_step) |-> !out_data[24]);

    // R8
    final_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_step) |-> (out_data >= 25'h0800000 && out_data <= 25'h1000000));

    // R11
    drop_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pack_en |-> (pack_head == 9'h000 || pack_head == 9'h1FF));
endmodule

bind nr_recip_refine nr_refine_chk u_refine_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_step  (out_step),
    .out_data  (out_data),
    .pack_en   (pack_en),
    .pack_head (pack_head)
);

// File: tb/test_nr_recip_refine.sv
module test_nr_recip_refine;
    localparam int     CLK_PERIOD = 10;
    localparam longint BIASV      = 64'd16777216;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_step = 1'b0;
    logic [23:0] in_opnd = '0;
    logic [24:0] in_seed = '0;
    logic        out_valid;
    logic        out_step;
    logic [24:0] out_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    // reference pipeline
    bit          e_v [3];
    bit          e_s [3];
    logic [24:0] e_d [3];
    bit          x_valid = 0;
    bit          x_step = 0;
    logic [24:0] x_data = '0;

    nr_recip_refine i_nr_recip_refine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_step(in_step),
        .in_opnd(in_opnd), .in_seed(in_seed),
        .out_valid(out_valid), .out_step(out_step), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [24:0] ref_product(longint b, longint s);
        longint p = b * s;
        longint f = ((p + (64'sd1 <<< 14)) >>> 15) & 64'hFFFF_FFFF;
        return 25'((~f) & 64'hFF_FFFF);
    endfunction

    function automatic logic [24:0] ref_finish(longint m, longint s);
        longint e = m;
        longint acc;
        if (m >= 64'sd8388608) e = m - 64'sd16777216;
        acc = (s <<< 32) + s * e + BIASV + (64'sd1 <<< 31);
        return 25'((acc >>> 32) & 64'h1FF_FFFF);
    endfunction

    function automatic longint pick_seed(longint b);
        real    ideal = (2.0 ** 47) / real'(b);
        longint s = longint'(ideal) + longint'($urandom % 1025) - 512;
        if (s > 64'sd16777216) s = 64'sd16777216;
        if (s < 64'sd8388609)  s = 64'sd8388609;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_s[i] = 0; e_d[i] = '0; end
            x_valid = 0; x_step = 0; x_data = '0;
        end else begin
            e_v[2] = e_v[1]; e_s[2] = e_s[1]; e_d[2] = e_d[1];
            e_v[1] = e_v[0]; e_s[1] = e_s[0]; e_d[1] = e_d[0];
            e_v[0] = in_valid; e_s[0] = in_step;
            e_d[0] = in_step ? ref_finish(longint'(in_opnd), longint'(in_seed))
                             : ref_product(longint'(in_opnd), longint'(in_seed));
            x_valid = e_v[2];
            if (e_v[2]) begin x_step = e_s[2]; x_data = e_d[2]; end
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison (R4, R5, R9, R1, R3, R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_valid == x_valid, "R5/R4 valid", out_valid, x_valid);
            if (x_valid) begin
                check(out_step == x_step, "R9 step tag", out_step, x_step);
                check(out_data == x_data, x_step ? "R3 finish data" : "R1 product data",
                      out_data, x_data);
            end else begin
                check(out_data == x_data, "R6 idle hold", out_data, x_data);
            end
        end
    end

    task automatic drive(bit v, bit st, longint op, longint sd);
        @(negedge clk);
        in_valid = v; in_step = st; in_opnd = 24'(op); in_seed = 25'(sd);
    endtask

    task automatic full_refine(longint b, longint s);
        logic [24:0] mid;
        real         err;
        drive(1, 0, b, s);
        drive(0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        mid = out_data;
        drive(1, 1, longint'(mid), s);
        drive(0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        err = real'(out_data) - (2.0 ** 47) / real'(b);
        if (err < 0.0) err = -err;
        checks++;
        if (err > 1.0 || out_data < 25'h0800000 || out_data > 25'h1000000) begin
            fails++;
            $display("FAIL R8 actual=%0h expected=%0f", out_data, (2.0 ** 47) / real'(b));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check(out_valid == 0, "R7 reset valid", out_valid, 0);
        check(out_step == 0, "R7 reset step", out_step, 0);
        check(out_data == 0, "R7 reset data", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // boundary cases for R8: b = 1.0 and b just below 2.0
        full_refine(64'd8388608, 64'd16777216);
        full_refine(64'd16777215, 64'd8388609);
        full_refine(64'd8388608, 64'd16776704);
        full_refine(64'd12582912, pick_seed(64'd12582912));

        // R8 with random operands through the block's own intermediate
        for (int k = 0; k < 40; k++) begin
            longint b = 64'd8388608 + longint'($urandom % 8388608);
            full_refine(b, pick_seed(b));
        end

        // R10 interleaved back-to-back issues, R5 throughput
        for (int k = 0; k < 400; k++) begin
            longint b = 64'd8388608 + longint'($urandom % 8388608);
            longint s = pick_seed(b);
            if (k % 2 == 0) drive(1, 0, b, s);
            else            drive(1, 1, longint'(ref_product(b, s)), s);
        end

        // sparse traffic with gaps, R6 hold during idle
        for (int k = 0; k < 400; k++) begin
            longint b = 64'd8388608 + longint'($urandom % 8388608);
            longint s = pick_seed(b);
            bit     v = ($urandom % 3) == 0;
            bit     st = $urandom % 2;
            drive(v, st, st ? longint'(ref_product(b, s)) : b, s);
        end

        drive(0, 0, 0, 0);
        repeat (5) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule